// File: doc/BRIEF.md
# Rotating Priority Resolver with In-Service Tracking

This block arbitrates among eight interrupt lines. It takes a vector of pending lines, which arrives already masked, and keeps its own record of which lines are in service. The lines are ranked from a movable base. The line at the base has rank 0, and ranks rise modulo eight from there. The block raises a request when the best pending line strictly outranks every line already in service, and it reports the number of that line. End-of-interrupt commands clear in-service bits and can move the base, so the winner rotates among equal-priority sources.

The request leaves through a valid/ready pair. `irq_out` is the valid and `irq_ack` is the ready, and a grant happens only in a cycle where both are high. Nothing is held against back-pressure. `irq_out` and `irq_line` are evaluated again every cycle from the current pending and in-service state, so the reported line can change while the request is unacknowledged. An acknowledge while `irq_out` is low has no effect.

When the block serves as the first stage of a cascade, setting `sfnm_en` leaves the cascade input out of the in-service comparison. A second-stage request arriving through that input can then interrupt a service already running on the same input. Decoding commands from a register bus and latching the requests are left to neighbouring logic. `NLINES` must be a power of two.

Top module: `rot_prio_resolver`

## Requirements
- R1: The rank of a set bit at line L is (L - base) mod 8, and the best line of a vector is its lowest-ranked set bit. `irq_line` reports that line as a 3-bit number.
- R2: `irq_out` is registered. At each clock edge it loads 1 only if the rank of the best bit of `pend_i` is strictly below the rank of the best in-service bit after that edge. An empty vector counts as rank 8. A pending line that is already in service therefore never raises a request.
- R3: While `sfnm_en` is 1, the cascade line (line 2) is left out of the in-service rank. If `pend_i` holds only line 2 and the in-service set is only line 2, `irq_out` rises with `irq_line` = 2 when `sfnm_en` is 1, and stays low when it is 0.
- R4: Command codes 1 and 2 act on the best in-service line under the current base. Code 1 clears that bit. Code 2 clears it and also sets the base to (line + 1) mod 8. With nothing in service, neither code changes the in-service set or the base.
- R5: Command code 3 clears the in-service bit at `cmd_line`. Code 4 does the same and also sets the base to (`cmd_line` + 1) mod 8.
- R6: Command code 5 sets the base to (`cmd_line` + 1) mod 8 and leaves the in-service set unchanged. Code 0 does nothing. Codes 6 and 7 are ignored.
- R7: A grant (`irq_ack` and `irq_out` both 1 at an edge) sets the in-service bit of the reported `irq_line`. An acknowledge while `irq_out` is 0 changes nothing.
- R8: When `aeoi_en` is 1, a grant leaves the in-service set unchanged. If `aeoi_rot_en` is also 1, the grant sets the base to (granted line + 1) mod 8.
- R9: An active-low reset clears the in-service set, the base and `irq_out`.
- R10: When a grant and a command fall in the same cycle, the grant is applied first and the command then acts on the result. A non-specific end-of-interrupt in that cycle can therefore clear the line that was just granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | 8 | Pending request vector, already masked |
| sfnm_en | input | 1 | Leave the cascade line out of the in-service rank |
| aeoi_en | input | 1 | Automatic end-of-interrupt on grant |
| aeoi_rot_en | input | 1 | Rotate the base on automatic end-of-interrupt |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0 to 5) |
| cmd_line | input | 3 | Line operand for specific and set-priority commands |
| irq_ack | input | 1 | Ready side of the request handshake |
| irq_out | output | 1 | Registered request (valid side) |
| irq_line | output | 3 | Line being requested |
| isr_out | output | 8 | In-service set |
| base_out | output | 3 | Current priority base |

## Verification
Pending vectors with one bit, two bits and all bits set are applied under several bases. This separates a rotated ranking from a fixed one, since the same vector picks a different line after the base moves. Pending lines above, equal to and below the current in-service rank show whether the comparison is strict. A non-specific end-of-interrupt issued with an empty in-service set shows that it has no effect. A grant and a command in the same cycle show the order in which they apply. The cascade line is tried with the nested option on and off, and automatic end-of-interrupt is tried with rotation on and off.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  localparam int RPR_OPW = 3;

  typedef enum logic [RPR_OPW-1:0] {
    OP_NOP      = 3'd0,
    OP_EOI      = 3'd1,
    OP_EOI_ROT  = 3'd2,
    OP_SPEC     = 3'd3,
    OP_SPEC_ROT = 3'd4,
    OP_SETPRI   = 3'd5
  } rpr_op_e;
endpackage

// File: rtl/rpr_rank_find.sv
// Finds the lowest-ranked set bit of vec with ranks measured from base.
// rank == N when vec is empty.
module rpr_rank_find #(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] base,
  output logic [LW:0]   rank,
  output logic [LW-1:0] line
);
  logic [N-1:0] rot;

  for (genvar k = 0; k < N; k++) begin : g_rot
    logic [LW-1:0] idx;
    assign idx    = LW'(k) + base;
    assign rot[k] = vec[idx];
  end

  always_comb begin
    rank = (LW+1)'(N);
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) rank = (LW+1)'(k);
    end
  end

  assign line = rank[LW-1:0] + base;
endmodule

// File: rtl/rpr_isr_ctrl.sv
// In-service set and priority base. The grant is applied first and the command after it.
module rpr_isr_ctrl
  import rpr_pkg::*;
#(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ack_fire,
  input  logic [LW-1:0]      ack_line,
  input  logic               aeoi_en,
  input  logic               aeoi_rot_en,
  input  logic               cmd_valid,
  input  logic [RPR_OPW-1:0] cmd_op,
  input  logic [LW-1:0]      cmd_line,
  output logic [N-1:0]       isr_q,
  output logic [LW-1:0]      base_q,
  output logic [N-1:0]       isr_nxt,
  output logic [LW-1:0]      base_nxt
);
  logic [N-1:0]  isr_a;
  logic [LW-1:0] base_a;
  logic [LW:0]   top_rank;
  logic [LW-1:0] top_line;
  logic          top_empty;
  rpr_op_e       op;

  // State after the grant stage.
  always_comb begin
    isr_a  = isr_q;
    base_a = base_q;
    if (ack_fire) begin
      if (!aeoi_en) begin
        isr_a[ack_line] = 1'b1;
      end else if (aeoi_rot_en) begin
        base_a = ack_line + LW'(1);
      end
    end
  end

  rpr_rank_find #(.N(N)) u_top (
    .vec  (isr_a),
    .base (base_a),
    .rank (top_rank),
    .line (top_line)
  );

  assign top_empty = top_rank[LW];
  assign op        = rpr_op_e'(cmd_op);

  always_comb begin
    isr_nxt  = isr_a;
    base_nxt = base_a;
    if (cmd_valid) begin
      case (op)
        OP_EOI: begin
          if (!top_empty) isr_nxt[top_line] = 1'b0;
        end
        OP_EOI_ROT: begin
          if (!top_empty) begin
            isr_nxt[top_line] = 1'b0;
            base_nxt          = top_line + LW'(1);
          end
        end
        OP_SPEC: begin
          isr_nxt[cmd_line] = 1'b0;
        end
        OP_SPEC_ROT: begin
          isr_nxt[cmd_line] = 1'b0;
          base_nxt          = cmd_line + LW'(1);
        end
        OP_SETPRI: begin
          base_nxt = cmd_line + LW'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= '0;
      base_q <= '0;
    end else begin
      isr_q  <= isr_nxt;
      base_q <= base_nxt;
    end
  end
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver
  import rpr_pkg::*;
#(
  parameter int NLINES       = 8,
  parameter int CASCADE_LINE = 2,
  localparam int LW = $clog2(NLINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NLINES-1:0]  pend_i,
  input  logic               sfnm_en,
  input  logic               aeoi_en,
  input  logic               aeoi_rot_en,
  input  logic               cmd_valid,
  input  logic [RPR_OPW-1:0] cmd_op,
  input  logic [LW-1:0]      cmd_line,
  input  logic               irq_ack,
  output logic               irq_out,
  output logic [LW-1:0]      irq_line,
  output logic [NLINES-1:0]  isr_out,
  output logic [LW-1:0]      base_out
);
  localparam logic [NLINES-1:0] CASC_BIT = NLINES'(1) << CASCADE_LINE;

  logic              irq_q;
  logic [LW-1:0]     line_q;
  logic              ack_fire;
  logic [NLINES-1:0] isr_q, isr_nxt, isr_cmp;
  logic [LW-1:0]     base_q, base_nxt;
  logic [LW:0]       pend_rank, cur_rank;
  logic [LW-1:0]     pend_line, cur_line;

  assign ack_fire = irq_ack & irq_q;

  rpr_isr_ctrl #(.N(NLINES)) u_isr (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_fire    (ack_fire),
    .ack_line    (line_q),
    .aeoi_en     (aeoi_en),
    .aeoi_rot_en (aeoi_rot_en),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_line    (cmd_line),
    .isr_q       (isr_q),
    .base_q      (base_q),
    .isr_nxt     (isr_nxt),
    .base_nxt    (base_nxt)
  );

  // Ranks are taken from the state as it will be after this edge.
  assign isr_cmp = sfnm_en ? (isr_nxt & ~CASC_BIT) : isr_nxt;

  rpr_rank_find #(.N(NLINES)) u_pend (
    .vec  (pend_i),
    .base (base_nxt),
    .rank (pend_rank),
    .line (pend_line)
  );

  rpr_rank_find #(.N(NLINES)) u_cur (
    .vec  (isr_cmp),
    .base (base_nxt),
    .rank (cur_rank),
    .line (cur_line)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      line_q <= '0;
    end else begin
      irq_q  <= (pend_rank < cur_rank);
      line_q <= pend_line;
    end
  end

  assign irq_out  = irq_q;
  assign irq_line = line_q;
  assign isr_out  = isr_q;
  assign base_out = base_q;

  logic unused_cur;
  assign unused_cur = ^cur_line;
endmodule

// File: rtl/rpr_checker.sv
module rpr_checker
  import rpr_pkg::*;
#(
  parameter int NLINES       = 8,
  parameter int CASCADE_LINE = 2,
  localparam int LW = $clog2(NLINES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NLINES-1:0]  pend_i,
  input logic               sfnm_en,
  input logic               aeoi_en,
  input logic               cmd_valid,
  input logic [RPR_OPW-1:0] cmd_op,
  input logic [LW-1:0]      cmd_line,
  input logic               irq_ack,
  input logic               irq_out,
  input logic [LW-1:0]      irq_line,
  input logic [NLINES-1:0]  isr_out,
  input logic [LW-1:0]      base_out
);
  localparam logic [NLINES-1:0] CASC_BIT = NLINES'(1) << CASCADE_LINE;

  logic grant;
  assign grant = irq_ack && irq_out;

  p_reset_clear_r9: assert property (@(posedge clk)
    !rst_n |=> (isr_out == '0 && base_out == '0 && !irq_out));

  p_empty_noirq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i == '0) |=> !irq_out);

  p_ack_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !aeoi_en && !cmd_valid) |=> isr_out[$past(irq_line)]);

  p_noack_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_out && !cmd_valid) |=> ($stable(isr_out) && $stable(base_out)));

  p_aeoi_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && aeoi_en && !cmd_valid) |=> $stable(isr_out));

  p_setpri_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SETPRI && !grant)
    |=> (base_out == $past(cmd_line) + LW'(1) && $stable(isr_out)));

  p_spec_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == OP_SPEC || cmd_op == OP_SPEC_ROT))
    |=> !isr_out[$past(cmd_line)]);

  p_ns_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == OP_EOI || cmd_op == OP_EOI_ROT) && isr_out == '0 && !grant)
    |=> (isr_out == '0 && $stable(base_out)));

  p_casc_nested_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sfnm_en && pend_i == CASC_BIT && isr_out == CASC_BIT && !cmd_valid && !grant)
    |=> (irq_out && irq_line == LW'(CASCADE_LINE)));

  p_casc_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sfnm_en && pend_i == CASC_BIT && isr_out == CASC_BIT && !cmd_valid && !grant)
    |=> !irq_out);
endmodule

bind rot_prio_resolver rpr_checker #(
  .NLINES       (NLINES),
  .CASCADE_LINE (CASCADE_LINE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pend_i    (pend_i),
  .sfnm_en   (sfnm_en),
  .aeoi_en   (aeoi_en),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_line  (cmd_line),
  .irq_ack   (irq_ack),
  .irq_out   (irq_out),
  .irq_line  (irq_line),
  .isr_out   (isr_out),
  .base_out  (base_out)
);

// File: tb/tb_rot_prio_resolver.sv
`timescale 1ns/1ps
module tb_rot_prio_resolver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pend_i = '0;
  logic       sfnm_en = 1'b0, aeoi_en = 1'b0, aeoi_rot_en = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0, cmd_line = '0;
  logic       irq_ack = 1'b0;
  logic       irq_out;
  logic [2:0] irq_line;
  logic [7:0] isr_out;
  logic [2:0] base_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  rot_prio_resolver dut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .sfnm_en(sfnm_en),
    .aeoi_en(aeoi_en), .aeoi_rot_en(aeoi_rot_en), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_line(cmd_line), .irq_ack(irq_ack),
    .irq_out(irq_out), .irq_line(irq_line), .isr_out(isr_out), .base_out(base_out)
  );

  // Fields: req[33:30] ack[29] op[28:26] line[25:23] pend[22:15]
  //         exp_irq[14] exp_line[13:11] exp_isr[10:3] exp_base[2:0]
  localparam int NV = 20;
  localparam logic [33:0] VEC [NV] = '{
    {4'd2,  1'b0,3'd0,3'd0,8'h00, 1'b0,3'd0,8'h00,3'd0}, // R2 empty pending
    {4'd1,  1'b0,3'd0,3'd0,8'h28, 1'b1,3'd3,8'h00,3'd0}, // R1 best of 3,5
    {4'd7,  1'b1,3'd0,3'd0,8'h28, 1'b0,3'd0,8'h08,3'd0}, // R7 grant 3, equal rank
    {4'd2,  1'b0,3'd0,3'd0,8'h29, 1'b1,3'd0,8'h08,3'd0}, // R2 higher preempts
    {4'd7,  1'b1,3'd0,3'd0,8'h28, 1'b0,3'd0,8'h09,3'd0}, // R7 nested grant 0
    {4'd4,  1'b0,3'd1,3'd0,8'h28, 1'b0,3'd0,8'h08,3'd0}, // R4 clears line 0
    {4'd4,  1'b0,3'd1,3'd0,8'h28, 1'b1,3'd3,8'h00,3'd0}, // R4 clears line 3
    {4'd6,  1'b0,3'd5,3'd4,8'h28, 1'b1,3'd5,8'h00,3'd5}, // R6 base 5
    {4'd7,  1'b1,3'd0,3'd0,8'h28, 1'b0,3'd0,8'h20,3'd5}, // R7 grant 5
    {4'd2,  1'b0,3'd0,3'd0,8'h08, 1'b0,3'd0,8'h20,3'd5}, // R2 lower pending
    {4'd4,  1'b0,3'd2,3'd0,8'h08, 1'b1,3'd3,8'h00,3'd6}, // R4 rotate to 6
    {4'd1,  1'b1,3'd0,3'd0,8'h88, 1'b1,3'd7,8'h08,3'd6}, // R1 7 beats 3 at base 6
    {4'd7,  1'b1,3'd0,3'd0,8'h08, 1'b0,3'd0,8'h88,3'd6}, // R7 grant 7
    {4'd5,  1'b0,3'd3,3'd7,8'h08, 1'b0,3'd0,8'h08,3'd6}, // R5 clear 7
    {4'd5,  1'b0,3'd4,3'd3,8'h00, 1'b0,3'd0,8'h00,3'd4}, // R5 clear 3, base 4
    {4'd1,  1'b0,3'd0,3'd0,8'hFF, 1'b1,3'd4,8'h00,3'd4}, // R1 all pending
    {4'd4,  1'b0,3'd1,3'd0,8'hFF, 1'b1,3'd4,8'h00,3'd4}, // R4 empty, no effect
    {4'd10, 1'b1,3'd5,3'd1,8'hFF, 1'b1,3'd2,8'h10,3'd2}, // R10 grant then base
    {4'd10, 1'b1,3'd1,3'd0,8'h00, 1'b0,3'd0,8'h10,3'd2}, // R10 grant then eoi
    {4'd4,  1'b0,3'd1,3'd0,8'h00, 1'b0,3'd0,8'h00,3'd2}  // R4 clear last
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic ack, input logic [2:0] op, input logic [2:0] ln,
                      input logic [7:0] pend);
    @(negedge clk);
    irq_ack   = ack;
    cmd_valid = (op != 3'd0);
    cmd_op    = op;
    cmd_line  = ln;
    pend_i    = pend;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_ack = 0; cmd_valid = 0; pend_i = '0;
    repeat (2) @(posedge clk);
    #1;
    chk("R9", "isr", isr_out, 0);
    chk("R9", "base", base_out, 0);
    chk("R9", "irq", irq_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R7: acknowledge while no request is ignored
    step(1'b1, 3'd0, 3'd0, 8'h00);
    chk("R7", "ignored ack isr", isr_out, 0);

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      string rq;
      v = VEC[i];
      rq = $sformatf("R%0d v%0d", v[33:30], i);
      step(v[29], v[28:26], v[25:23], v[22:15]);
      chk(rq, "irq", irq_out, v[14]);
      if (v[14]) chk(rq, "line", irq_line, v[13:11]);
      chk(rq, "isr", isr_out, v[10:3]);
      chk(rq, "base", base_out, v[2:0]);
    end

    // R3: cascade line with nested option
    do_reset();
    step(1'b0, 3'd0, 3'd0, 8'h04);
    chk("R3", "irq", irq_out, 1);
    chk("R3", "line", irq_line, 2);
    step(1'b1, 3'd0, 3'd0, 8'h04);
    chk("R3", "isr", isr_out, 8'h04);
    chk("R3", "plain irq", irq_out, 0);
    @(negedge clk); sfnm_en = 1'b1;
    step(1'b0, 3'd0, 3'd0, 8'h04);
    chk("R3", "nested irq", irq_out, 1);
    chk("R3", "nested line", irq_line, 2);
    @(negedge clk); sfnm_en = 1'b0;

    // R8: automatic end-of-interrupt
    do_reset();
    @(negedge clk); aeoi_en = 1'b1;
    step(1'b0, 3'd0, 3'd0, 8'h40);
    chk("R8", "irq", irq_out, 1);
    chk("R8", "line", irq_line, 6);
    step(1'b1, 3'd0, 3'd0, 8'h40);
    chk("R8", "isr", isr_out, 0);
    chk("R8", "base", base_out, 0);
    chk("R8", "irq again", irq_out, 1);
    @(negedge clk); aeoi_rot_en = 1'b1;
    step(1'b1, 3'd0, 3'd0, 8'h40);
    chk("R8", "rot isr", isr_out, 0);
    chk("R8", "rot base", base_out, 7);
    chk("R8", "rot line", irq_line, 6);
    @(negedge clk); aeoi_en = 1'b0; aeoi_rot_en = 1'b0;

    // R9: reset in the middle of activity
    step(1'b0, 3'd5, 3'd2, 8'h01);
    chk("R6", "base", base_out, 3);
    do_reset();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule